// File: doc/BRIEF.md
# Statistics Counter Bank with Memory Dump

The block holds a bank of frame-statistics counters. Each counter has its own event strobe, and one frame can raise any mix of them in a single cycle. Each counter wraps silently at its full width. Software sees the bank only through a dump. It first loads a dump base address. It then issues a command, either a plain dump or a dump-and-reset.

The dump sequencer streams the counters in index order through a valid/ready memory write port. After the counters it writes one completion dword. The completion value tells a plain dump from a dump-and-reset. In the reset mode, each counter is cleared in the same cycle its value is captured. An event that arrives in that cycle is kept in the cleared counter. Counters that have not been reached yet keep counting while the dump runs.

Top module: `stat_dump_bank`

## Requirements
- R1: After reset, `busy_o` and `wr_valid_o` are low and every counter is zero, so a first dump returns zeros.
- R2: Counter i adds one for every cycle in which `evt_inc_i[i]` is high. Any number of strobes may be high in the same cycle, and each one counts.
- R3: A counter is CNT_W bits wide (32 by default). It wraps from all-ones to zero and gives no indication of the wrap.
- R4: Writing the base address clears bits 1:0 of the value. Counter i is written to base + 4*i, in order from i = 0 to NUM_CNT-1.
- R5: After the last counter, one completion dword goes to base + 4*NUM_CNT. Its value is 0x0000A005 after a plain dump (`dump_clr_i`=0) and 0x0000A007 after a dump-and-reset (`dump_clr_i`=1).
- R6: A dump-and-reset leaves each counter at zero plus any increment that arrives in its capture cycle. A plain dump leaves every counter unchanged.
- R7: A counter that has not been captured yet keeps counting during a dump. Each written word holds the value the counter had when it was captured.
- R8: Each dump makes exactly NUM_CNT+1 accepted writes. A write is accepted when `wr_valid_o` and `wr_ready_i` are both high. While `wr_valid_o` is high and `wr_ready_i` is low, the address and data hold steady.
- R9: A command accepted from idle raises `busy_o` on the next cycle. `busy_o` stays high until the completion dword is accepted. A command that arrives while busy is ignored. The base address is latched when a command is accepted.
- R10: Once the completion dword is accepted, `wr_valid_o` stays low until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_inc_i | input | NUM_CNT | One increment strobe for each counter |
| base_wr_i | input | 1 | Loads the dump base address |
| base_data_i | input | ADDR_W | Base address value (bits 1:0 are dropped) |
| dump_req_i | input | 1 | Dump command; taken only when idle |
| dump_clr_i | input | 1 | With dump_req_i: 1 selects dump-and-reset |
| wr_ready_i | input | 1 | The memory write port can take a word |
| busy_o | output | 1 | A dump is in progress |
| wr_valid_o | output | 1 | A write word is presented |
| wr_addr_o | output | ADDR_W | Byte address of the write |
| wr_data_o | output | DATA_W | Write data |

## Verification
Two things can land in the same cycle: a counter's capture-and-clear during a dump-and-reset, and an event strobe on that same counter. The bench provokes this by holding every strobe high from the command cycle through the last capture. As a result, each counter's capture cycle sees both an increment and a clear. The bench judges the result by conservation. The dumped value must equal the count before the dump plus the increments up to capture. A following plain dump must then show exactly the increments from the capture cycle onward, so no event is lost or counted twice.

// File: rtl/stat_dump_pkg.sv
package stat_dump_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CNT,
    SQ_STAT,
    SQ_FIN
  } seq_state_e;

  localparam logic [15:0] CODE_PLAIN = 16'hA005;
  localparam logic [15:0] CODE_CLEAR = 16'hA007;

  function automatic logic [15:0] done_code(input logic clr_mode);
    return clr_mode ? CODE_CLEAR : CODE_PLAIN;
  endfunction

endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] val_o
);

  // Clear and increment combine: a same-cycle event lands in the cleared value.
  always_ff @(posedge clk) begin
    if (rst) begin
      val_o <= '0;
    end else if (inc_i || clr_i) begin
      val_o <= (clr_i ? '0 : val_o) + W'(inc_i);
    end
  end

endmodule

// File: rtl/dump_sequencer.sv
module dump_sequencer
  import stat_dump_pkg::*;
#(
  parameter int NUM_CNT = 16,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cmd_valid_i,
  input  logic                           cmd_clr_i,
  input  logic [ADDR_W-1:0]              base_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_i,
  output logic [NUM_CNT-1:0]             cap_clr_o,
  output logic                           busy_o,
  output logic                           wr_valid_o,
  output logic [ADDR_W-1:0]              wr_addr_o,
  output logic [DATA_W-1:0]              wr_data_o,
  input  logic                           wr_ready_i
);

  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int LAST  = NUM_CNT - 1;
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(NUM_CNT * 4);

  seq_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              mode_clr;
  logic [ADDR_W-1:0] base_q;
  logic              adv;
  logic              cap;
  logic [CNT_W-1:0]  cnt_sel;

  // The output register may reload when it is empty or its word is leaving.
  assign adv     = !wr_valid_o || wr_ready_i;
  assign cap     = (state == SQ_CNT) && adv;
  assign cnt_sel = cnt_i[idx];

  always_comb begin
    cap_clr_o = '0;
    if (cap && mode_clr) begin
      cap_clr_o[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      idx        <= '0;
      mode_clr   <= 1'b0;
      base_q     <= '0;
      busy_o     <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (cmd_valid_i) begin
            state    <= SQ_CNT;
            idx      <= '0;
            mode_clr <= cmd_clr_i;
            base_q   <= base_i;
            busy_o   <= 1'b1;
          end
        end
        SQ_CNT: begin
          if (adv) begin
            wr_valid_o <= 1'b1;
            wr_addr_o  <= base_q + (ADDR_W'(idx) << 2);
            wr_data_o  <= DATA_W'(cnt_sel);
            if (idx == IDX_W'(LAST)) begin
              state <= SQ_STAT;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        SQ_STAT: begin
          if (adv) begin
            wr_valid_o <= 1'b1;
            wr_addr_o  <= base_q + STAT_OFS;
            wr_data_o  <= DATA_W'(done_code(mode_clr));
            state      <= SQ_FIN;
          end
        end
        SQ_FIN: begin
          if (wr_ready_i) begin
            wr_valid_o <= 1'b0;
            busy_o     <= 1'b0;
            state      <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stat_dump_bank.sv
module stat_dump_bank #(
  parameter int NUM_CNT = 16,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] evt_inc_i,
  input  logic               base_wr_i,
  input  logic [ADDR_W-1:0]  base_data_i,
  input  logic               dump_req_i,
  input  logic               dump_clr_i,
  input  logic               wr_ready_i,
  output logic               busy_o,
  output logic               wr_valid_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  logic [ADDR_W-1:0]             base_q;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CNT-1:0]            cap_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (base_wr_i) begin
      base_q <= base_data_i & ALIGN_MASK;
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    stat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc_i (evt_inc_i[g]),
      .clr_i (cap_clr[g]),
      .val_o (cnt_all[g])
    );
  end

  dump_sequencer #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (dump_req_i),
    .cmd_clr_i   (dump_clr_i),
    .base_i      (base_q),
    .cnt_i       (cnt_all),
    .cap_clr_o   (cap_clr),
    .busy_o      (busy_o),
    .wr_valid_o  (wr_valid_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_ready_i  (wr_ready_i)
  );

endmodule

// File: rtl/stat_dump_bank_chk.sv
module stat_dump_bank_chk #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              inc0,
  input logic              clr0,
  input logic [CNT_W-1:0]  cnt0,
  input logic              dump_req_i,
  input logic              busy_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o
);

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !wr_valid_o); // R10

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> (wr_addr_o[1:0] == 2'b00)); // R4

  AST_CMD_START: assert property (@(posedge clk) disable iff (rst)
    (dump_req_i && !busy_o) |=> busy_o); // R9

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc0 && !clr0) |=> (cnt0 == $past(cnt0) + CNT_W'(1))); // R2

  AST_CLR_KEEPS_EVT: assert property (@(posedge clk) disable iff (rst)
    clr0 |=> (cnt0 == CNT_W'($past(inc0)))); // R6

endmodule

bind stat_dump_bank stat_dump_bank_chk #(
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inc0       (evt_inc_i[0]),
  .clr0       (cap_clr[0]),
  .cnt0       (cnt_all[0]),
  .dump_req_i (dump_req_i),
  .busy_o     (busy_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o)
);

// File: tb/stat_dump_bank_test.sv
module stat_dump_bank_test;

  localparam int CLK_P = 10;
  localparam int N     = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic [N-1:0] evt_inc = '0;
  logic         base_wr = 1'b0;
  logic [31:0]  base_data = '0;
  logic         dump_req = 1'b0;
  logic         dump_clr = 1'b0;
  logic         rdy = 1'b1;
  logic         busy, wv;
  logic [31:0]  wa_o, wd_o;

  stat_dump_bank uut (
    .clk(clk), .rst(rst), .evt_inc_i(evt_inc), .base_wr_i(base_wr),
    .base_data_i(base_data), .dump_req_i(dump_req), .dump_clr_i(dump_clr),
    .wr_ready_i(rdy), .busy_o(busy), .wr_valid_o(wv),
    .wr_addr_o(wa_o), .wr_data_o(wd_o)
  );

  logic [N-1:0] n_inc = '0;
  logic         n_req = 1'b0;
  logic         n_busy, n_wv;
  logic [31:0]  n_wa, n_wd;

  stat_dump_bank #(.CNT_W(4)) uut_narrow (
    .clk(clk), .rst(rst), .evt_inc_i(n_inc), .base_wr_i(1'b0),
    .base_data_i(32'h0), .dump_req_i(n_req), .dump_clr_i(1'b0),
    .wr_ready_i(1'b1), .busy_o(n_busy), .wr_valid_o(n_wv),
    .wr_addr_o(n_wa), .wr_data_o(n_wd)
  );

  // Write recorders
  logic [31:0] rec_a [64];
  logic [31:0] rec_d [64];
  int          wn = 0;
  logic [31:0] nrec_d [64];
  int          nwn = 0;

  always @(posedge clk) begin
    if (!rst && wv && rdy) begin
      rec_a[wn % 64] <= wa_o;
      rec_d[wn % 64] <= wd_o;
      wn <= wn + 1;
    end
    if (!rst && n_wv) begin
      nrec_d[nwn % 64] <= n_wd;
      nwn <= nwn + 1;
    end
  end

  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  logic [31:0] model [N];
  logic [31:0] exp_dump [N];
  logic [7:0]  lfsr = 8'h5B;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_inc(input logic [N-1:0] mask);
    @(negedge clk);
    evt_inc = mask;
    @(negedge clk);
    evt_inc = '0;
    for (int i = 0; i < N; i++) if (mask[i]) model[i] = model[i] + 1;
  endtask

  task automatic load_base(input logic [31:0] b);
    @(negedge clk);
    base_wr = 1'b1;
    base_data = b;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic wait_idle(input bit stall);
    for (int k = 0; k < 600 && busy; k++) begin
      @(negedge clk);
      if (stall) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rdy = lfsr[0];
      end
    end
    rdy = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_dump(input bit clr, input bit stall, output int s);
    s = wn;
    @(negedge clk);
    dump_req = 1'b1;
    dump_clr = clr;
    @(negedge clk);
    dump_req = 1'b0;
    dump_clr = 1'b0;
    wait_idle(stall);
  endtask

  task automatic check_dump(input int s, input logic [31:0] b,
                            input logic [15:0] code, input string tag);
    check(wn - s == N + 1, {tag, " R8 write count"}, 32'(wn - s), 32'(N + 1));
    for (int i = 0; i < N; i++) begin
      check(rec_a[(s + i) % 64] == b + 32'(4 * i), {tag, " R4 addr"},
            rec_a[(s + i) % 64], b + 32'(4 * i));
      check(rec_d[(s + i) % 64] == exp_dump[i], {tag, " data"},
            rec_d[(s + i) % 64], exp_dump[i]);
    end
    check(rec_a[(s + N) % 64] == b + 32'(4 * N), {tag, " R5 status addr"},
          rec_a[(s + N) % 64], b + 32'(4 * N));
    check(rec_d[(s + N) % 64] == {16'h0, code}, {tag, " R5 status code"},
          rec_d[(s + N) % 64], {16'h0, code});
  endtask

  task automatic t_reset;
    int s;
    check(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
    check(wv == 1'b0, "R1 wr_valid after reset", 32'(wv), 0);
    load_base(32'h0000_0100);
    run_dump(1'b0, 1'b0, s);
    for (int i = 0; i < N; i++) exp_dump[i] = 32'h0;
    check_dump(s, 32'h100, 16'hA005, "R1 zero dump");
  endtask

  task automatic t_incr;
    int s;
    for (int r = 0; r < N; r++) pulse_inc(16'hFFFF >> r);
    for (int r = 0; r < 3; r++) pulse_inc(16'hA5A5);
    load_base(32'h0000_2003);
    run_dump(1'b0, 1'b0, s);
    for (int i = 0; i < N; i++) exp_dump[i] = model[i];
    check_dump(s, 32'h2000, 16'hA005, "R2 multi-strobe dump");
    run_dump(1'b0, 1'b0, s);
    check_dump(s, 32'h2000, 16'hA005, "R6 plain dump keeps values");
  endtask

  task automatic t_clr_race;
    int s;
    s = wn;
    @(negedge clk);
    dump_req = 1'b1;
    dump_clr = 1'b1;
    evt_inc = '1;
    @(negedge clk);
    dump_req = 1'b0;
    dump_clr = 1'b0;
    repeat (17) @(negedge clk);
    evt_inc = '0;
    wait_idle(1'b0);
    for (int i = 0; i < N; i++) exp_dump[i] = model[i] + 32'(i + 1);
    check_dump(s, 32'h2000, 16'hA007, "R7 race dump-and-reset");
    for (int i = 0; i < N; i++) model[i] = 32'(17 - i);
    run_dump(1'b0, 1'b0, s);
    for (int i = 0; i < N; i++) exp_dump[i] = model[i];
    check_dump(s, 32'h2000, 16'hA005, "R6 same-cycle event kept");
  endtask

  task automatic t_busy_ignore;
    int s;
    int w0;
    s = wn;
    @(negedge clk);
    dump_req = 1'b1;
    @(negedge clk);
    dump_req = 1'b0;
    repeat (3) @(negedge clk);
    dump_req = 1'b1;
    dump_clr = 1'b1;
    base_wr = 1'b1;
    base_data = 32'h0000_3000;
    @(negedge clk);
    dump_req = 1'b0;
    dump_clr = 1'b0;
    base_wr = 1'b0;
    wait_idle(1'b0);
    check_dump(s, 32'h2000, 16'hA005, "R9 busy command ignored");
    w0 = wn;
    repeat (20) @(negedge clk);
    check(wn == w0, "R10 no writes after completion", 32'(wn - w0), 0);
    check(wv == 1'b0 && busy == 1'b0, "R10 idle after completion",
          {30'h0, busy, wv}, 0);
    run_dump(1'b0, 1'b0, s);
    check_dump(s, 32'h3000, 16'hA005, "R9 values kept, new base used");
  endtask

  task automatic t_stall;
    int s;
    pulse_inc(16'h8001);
    for (int i = 0; i < N; i++) exp_dump[i] = model[i];
    run_dump(1'b1, 1'b1, s);
    check_dump(s, 32'h3000, 16'hA007, "R8 stalled dump-and-reset");
    for (int i = 0; i < N; i++) begin
      model[i] = 32'h0;
      exp_dump[i] = 32'h0;
    end
    run_dump(1'b0, 1'b1, s);
    check_dump(s, 32'h3000, 16'hA005, "R6 cleared after stalled dump");
  endtask

  task automatic t_wrap;
    int s;
    for (int r = 0; r < 17; r++) begin
      @(negedge clk);
      n_inc = {13'h0, (r < 16), (r < 15), 1'b1};
      @(negedge clk);
      n_inc = '0;
    end
    s = nwn;
    @(negedge clk);
    n_req = 1'b1;
    @(negedge clk);
    n_req = 1'b0;
    for (int k = 0; k < 100 && n_busy; k++) @(negedge clk);
    @(negedge clk);
    check(nwn - s == N + 1, "R3 narrow write count", 32'(nwn - s), 32'(N + 1));
    check(nrec_d[s % 64] == 32'h1, "R3 wrap 17 mod 16", nrec_d[s % 64], 32'h1);
    check(nrec_d[(s + 1) % 64] == 32'hF, "R3 max value held",
          nrec_d[(s + 1) % 64], 32'hF);
    check(nrec_d[(s + 2) % 64] == 32'h0, "R3 wrap to zero",
          nrec_d[(s + 2) % 64], 32'h0);
    check(nrec_d[(s + N) % 64] == 32'hA005, "R5 narrow status",
          nrec_d[(s + N) % 64], 32'hA005);
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_incr();
    t_clr_race();
    t_busy_ignore();
    t_stall();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule